// File: doc/BRIEF.md
# Pulsed-Frame Synchronous Serial Master

This block is a full-duplex synchronous serial master for one external slave. Software-side logic writes words into a small transmit FIFO. For each word the block drives a serial clock, a one-period frame pulse and a transmit data line, and it samples a receive data line. Each returned word lands in a small receive FIFO, right-aligned. The frame length is set from 4 to 16 bits. A divider sets the serial clock rate. An enable input starts and stops the whole serial engine.

A frame begins with a high pulse on the frame line that lasts one serial-clock period, and the data then follows MSB first. When the transmit FIFO still holds a word as the current frame reaches its last bit, the next frame pulse overlaps that last bit period. The next MSB then follows without a gap. When no data is queued, the clock and frame lines rest low and the data line keeps the last bit it sent.

Top module: `pfs_master`

## Requirements
- R1: After reset, `ser_clk`, `frm_pulse` and `ser_out` are 0, `rx_empty` is 1, and `tx_full` and `rx_overrun` are 0. While the transmit FIFO is empty, `ser_clk` and `frm_pulse` stay low.
- R2: When the transmit FIFO holds a word, `frm_pulse` rises together with a rising edge of `ser_clk`. It stays high for exactly one serial-clock period, which is 2×(div_n+1) system clocks.
- R3: On the rising `ser_clk` edge after the frame pulse, `ser_out` carries the MSB of the frame. Each later rising edge drives the next lower bit, down to bit 0. `ser_out` changes only on a rising `ser_clk` edge while the block is enabled.
- R4: `frame_cfg` holds the frame length minus one. Values 3 to 15 select 4 to 16 bits, and values 0 to 2 select 4 bits. Bits of a transmit word above the frame length are not sent.
- R5: `ser_clk` is high for div_n+1 system clocks in each period, giving a period of 2×(div_n+1) system clocks.
- R6: The block samples `ser_in` on each falling edge of `ser_clk` during the data bits, MSB first. On the next serial-clock rise after the LSB, it writes the word into the receive FIFO right-aligned, with the upper bits zero.
- R7: After a frame ends with no further word queued, `ser_out` keeps the value of bit 0 of that frame, and `ser_clk` and `frm_pulse` stay low.
- R8: While `enable` is low, `ser_out`, `ser_clk` and `frm_pulse` are forced to 0 from the next clock on, and any frame in progress is abandoned.
- R9: If the transmit FIFO is not empty during the LSB period of a frame, the next frame pulse is asserted in that period. Consecutive frame pulses then rise exactly (frame length)×2×(div_n+1) system clocks apart.
- R10: A word that completes while the receive FIFO is full is dropped and the words already stored are kept. `rx_overrun` then goes to 1 and stays at 1 until reset.
- R11: While the receive FIFO is empty, `rx_data` reads 0 and a pop changes nothing. A push while `tx_full` is 1 is ignored.
- R12: Both FIFOs hold FIFO_DEPTH (default 4) words and return them in the order they were written. `rx_data` shows the oldest word before it is popped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Runs the serial engine and divider when high |
| div_n | input | 8 | Divider value N; serial period is 2×(N+1) clocks |
| frame_cfg | input | 4 | Frame length minus one |
| tx_push | input | 1 | Writes tx_data into the transmit FIFO |
| tx_data | input | 16 | Word to send, right-aligned |
| tx_full | output | 1 | Transmit FIFO full |
| rx_pop | input | 1 | Removes the oldest received word |
| rx_data | output | 16 | Oldest received word, 0 when empty |
| rx_empty | output | 1 | Receive FIFO empty |
| rx_overrun | output | 1 | Sticky flag for a dropped received word |
| ser_clk | output | 1 | Serial clock to the slave |
| frm_pulse | output | 1 | One-period frame marker |
| ser_out | output | 1 | Serial transmit data |
| ser_in | input | 1 | Serial receive data |

## Verification
The serial outputs are registered, so each one moves one system clock after the internal edge tick that caused it. The bench therefore measures durations at the falling system-clock edge, as high times of N+1 clocks and 2×(N+1) clocks, and does not compare against absolute cycle numbers. A slave model captures `ser_out` on the falling `ser_clk` edges and compares each complete frame against a queue filled by the push task. It drives `ser_in` shortly after each rising `ser_clk` edge, well before the sampling tick. A received word is due at most one serial period after its LSB, so the bench waits for the transmit queue to drain and then several more serial periods before it pops and compares against the queue of words the slave sent. Frame-pulse spacing in continuous runs is taken from a system-clock cycle counter and compared with the frame length times the serial period.

// File: rtl/pfs_pkg.sv
package pfs_pkg;
    localparam int WORD_W = 16;
    localparam int CFG_W  = 4;
    localparam int LEN_W  = $clog2(WORD_W + 1);

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PULSE = 2'd1,
        ST_DATA  = 2'd2
    } eng_state_e;

    typedef struct packed {
        logic rise;
        logic fall;
    } sclk_tick_t;

    function automatic logic [LEN_W-1:0] frame_len(input logic [CFG_W-1:0] cfg);
        if (cfg < CFG_W'(3))
            return LEN_W'(4);
        return LEN_W'(cfg) + LEN_W'(1);
    endfunction

    function automatic logic [WORD_W-1:0] len_mask(input logic [LEN_W-1:0] len);
        logic [WORD_W:0] m;
        m = ((WORD_W+1)'(1) << len) - (WORD_W+1)'(1);
        return m[WORD_W-1:0];
    endfunction
endpackage

// File: rtl/pfs_fifo.sv
module pfs_fifo #(
    parameter int W     = 16,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] wdata,
    input  logic         pop,
    output logic [W-1:0] rdata,
    output logic         empty,
    output logic         full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] count;
    logic          do_push, do_pop;

    assign empty   = (count == '0);
    assign full    = (count == CW'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign rdata   = mem[rd_ptr];

    function automatic logic [AW-1:0] next_ptr(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (do_push)
            mem[wr_ptr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push)
                wr_ptr <= next_ptr(wr_ptr);
            if (do_pop)
                rd_ptr <= next_ptr(rd_ptr);
            if (do_push && !do_pop)
                count <= count + CW'(1);
            else if (do_pop && !do_push)
                count <= count - CW'(1);
        end
    end
endmodule

// File: rtl/pfs_clkgen.sv
module pfs_clkgen #(
    parameter int DIV_W = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 enable,
    input  logic [DIV_W-1:0]     div_n,
    output pfs_pkg::sclk_tick_t  tick
);
    logic [DIV_W-1:0] cnt;
    logic             phase;
    logic             wrap;

    assign wrap      = enable && (cnt >= div_n);
    assign tick.rise = wrap && !phase;
    assign tick.fall = wrap && phase;

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            cnt   <= '0;
            phase <= 1'b0;
        end else if (wrap) begin
            cnt   <= '0;
            phase <= ~phase;
        end else begin
            cnt <= cnt + DIV_W'(1);
        end
    end
endmodule

// File: rtl/pfs_engine.sv
module pfs_engine
    import pfs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  sclk_tick_t        tick,
    input  logic [CFG_W-1:0]  frame_cfg,
    input  logic              tx_empty,
    input  logic [WORD_W-1:0] tx_head,
    output logic              tx_pop,
    input  logic              ser_in,
    output logic              ser_clk,
    output logic              frm_pulse,
    output logic              ser_out,
    output logic              rx_push,
    output logic [WORD_W-1:0] rx_word
);
    localparam int IDX_W = $clog2(WORD_W);

    eng_state_e        state;
    logic [LEN_W-1:0]  bidx;
    logic [LEN_W-1:0]  len_load;
    logic [LEN_W-1:0]  len_act;
    logic [WORD_W-1:0] tx_sh;
    logic [WORD_W-1:0] rx_sh;
    logic [WORD_W-1:0] rx_next;
    logic              chained;
    logic              rx_pend;
    logic              start_idle;
    logic              start_chain;
    logic              last_bit_next;

    assign last_bit_next = (state == ST_DATA) && (bidx == LEN_W'(1));
    assign start_idle    = tick.rise && (state == ST_IDLE) && !tx_empty;
    assign start_chain   = tick.rise && last_bit_next && !tx_empty;
    assign tx_pop        = start_idle || start_chain;
    assign rx_push       = tick.rise && rx_pend;
    assign rx_next       = {rx_sh[WORD_W-2:0], ser_in};

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            state     <= ST_IDLE;
            bidx      <= '0;
            len_load  <= LEN_W'(4);
            len_act   <= LEN_W'(4);
            tx_sh     <= '0;
            rx_sh     <= '0;
            rx_word   <= '0;
            chained   <= 1'b0;
            rx_pend   <= 1'b0;
            ser_clk   <= 1'b0;
            frm_pulse <= 1'b0;
            ser_out   <= 1'b0;
        end else if (tick.rise) begin
            rx_pend <= 1'b0;
            if (tx_pop) begin
                tx_sh     <= tx_head;
                len_load  <= frame_len(frame_cfg);
                frm_pulse <= 1'b1;
            end
            unique case (state)
                ST_IDLE: begin
                    if (start_idle) begin
                        ser_clk <= 1'b1;
                        state   <= ST_PULSE;
                    end
                end
                ST_PULSE: begin
                    frm_pulse <= 1'b0;
                    ser_clk   <= 1'b1;
                    ser_out   <= tx_sh[IDX_W'(len_load - LEN_W'(1))];
                    bidx      <= len_load - LEN_W'(1);
                    len_act   <= len_load;
                    state     <= ST_DATA;
                end
                ST_DATA: begin
                    if (bidx != '0) begin
                        ser_clk <= 1'b1;
                        ser_out <= tx_sh[IDX_W'(bidx - LEN_W'(1))];
                        bidx    <= bidx - LEN_W'(1);
                        if (start_chain)
                            chained <= 1'b1;
                    end else begin
                        frm_pulse <= 1'b0;
                        if (chained) begin
                            chained <= 1'b0;
                            ser_clk <= 1'b1;
                            ser_out <= tx_sh[IDX_W'(len_load - LEN_W'(1))];
                            bidx    <= len_load - LEN_W'(1);
                            len_act <= len_load;
                        end else begin
                            state <= ST_IDLE;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end else if (tick.fall) begin
            ser_clk <= 1'b0;
            if (state == ST_DATA) begin
                rx_sh <= rx_next;
                if (bidx == '0) begin
                    rx_word <= rx_next & len_mask(len_act);
                    rx_pend <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/pfs_master.sv
module pfs_master
    import pfs_pkg::*;
#(
    parameter int FIFO_DEPTH = 4,
    parameter int DIV_W      = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic [DIV_W-1:0]  div_n,
    input  logic [CFG_W-1:0]  frame_cfg,
    input  logic              tx_push,
    input  logic [WORD_W-1:0] tx_data,
    output logic              tx_full,
    input  logic              rx_pop,
    output logic [WORD_W-1:0] rx_data,
    output logic              rx_empty,
    output logic              rx_overrun,
    output logic              ser_clk,
    output logic              frm_pulse,
    output logic              ser_out,
    input  logic              ser_in
);
    sclk_tick_t        tick;
    logic              tx_empty;
    logic              tx_pop;
    logic [WORD_W-1:0] tx_head;
    logic              rx_push;
    logic              rx_full;
    logic [WORD_W-1:0] rx_word;
    logic [WORD_W-1:0] rx_head;

    pfs_clkgen #(.DIV_W(DIV_W)) u_clkgen (
        .clk    (clk),
        .rst    (rst),
        .enable (enable),
        .div_n  (div_n),
        .tick   (tick)
    );

    pfs_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_tx_fifo (
        .clk   (clk),
        .rst   (rst),
        .push  (tx_push),
        .wdata (tx_data),
        .pop   (tx_pop),
        .rdata (tx_head),
        .empty (tx_empty),
        .full  (tx_full)
    );

    pfs_engine u_engine (
        .clk       (clk),
        .rst       (rst),
        .enable    (enable),
        .tick      (tick),
        .frame_cfg (frame_cfg),
        .tx_empty  (tx_empty),
        .tx_head   (tx_head),
        .tx_pop    (tx_pop),
        .ser_in    (ser_in),
        .ser_clk   (ser_clk),
        .frm_pulse (frm_pulse),
        .ser_out   (ser_out),
        .rx_push   (rx_push),
        .rx_word   (rx_word)
    );

    pfs_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_rx_fifo (
        .clk   (clk),
        .rst   (rst),
        .push  (rx_push),
        .wdata (rx_word),
        .pop   (rx_pop),
        .rdata (rx_head),
        .empty (rx_empty),
        .full  (rx_full)
    );

    assign rx_data = rx_empty ? '0 : rx_head;

    always_ff @(posedge clk) begin
        if (rst)
            rx_overrun <= 1'b0;
        else if (rx_push && rx_full)
            rx_overrun <= 1'b1;
    end
endmodule

// File: rtl/pfs_checker.sv
module pfs_checker (
    input logic clk,
    input logic rst,
    input logic enable,
    input logic ser_clk,
    input logic frm,
    input logic ser_out,
    input logic rx_overrun,
    input logic rx_full,
    input logic rx_push
);
    AST_FRM_ON_RISE: assert property (@(posedge clk) disable iff (rst)
        $rose(frm) |-> $rose(ser_clk)); // R2

    AST_TXD_ON_RISE: assert property (@(posedge clk) disable iff (rst)
        (enable && $past(enable) && !$stable(ser_out)) |-> $rose(ser_clk)); // R3

    AST_DISABLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !enable |=> (!ser_clk && !frm && !ser_out)); // R8

    AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (rst)
        rx_overrun |=> rx_overrun); // R10

    AST_OVERRUN_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_overrun) |-> $past(rx_full && rx_push)); // R10
endmodule

bind pfs_master pfs_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .enable     (enable),
    .ser_clk    (ser_clk),
    .frm        (frm_pulse),
    .ser_out    (ser_out),
    .rx_overrun (rx_overrun),
    .rx_full    (rx_full),
    .rx_push    (rx_push)
);

// File: tb/test_pfs_master.sv
`timescale 1ns/1ps
module test_pfs_master;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        enable = 1'b0;
    logic [7:0]  div_n = 8'd1;
    logic [3:0]  frame_cfg = 4'd7;
    logic        tx_push = 1'b0;
    logic [15:0] tx_data = '0;
    logic        tx_full;
    logic        rx_pop = 1'b0;
    logic [15:0] rx_data;
    logic        rx_empty;
    logic        rx_overrun;
    logic        ser_clk, frm_pulse, ser_out;
    logic        ser_in = 1'b0;

    pfs_master i_pfs_master (
        .clk(clk), .rst(rst), .enable(enable), .div_n(div_n), .frame_cfg(frame_cfg),
        .tx_push(tx_push), .tx_data(tx_data), .tx_full(tx_full),
        .rx_pop(rx_pop), .rx_data(rx_data), .rx_empty(rx_empty), .rx_overrun(rx_overrun),
        .ser_clk(ser_clk), .frm_pulse(frm_pulse), .ser_out(ser_out), .ser_in(ser_in)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_checks = 0;
    int n_fail   = 0;
    int cur_len  = 8;
    int cycle    = 0;
    bit finished = 0;

    logic [15:0] tx_exp[$];
    logic [15:0] rx_exp[$];
    logic [15:0] slave_q[$];
    int          gaps[$];

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] mask_of(input int len);
        return 16'((32'd1 << len) - 1);
    endfunction

    function automatic int len_of(input logic [3:0] cfg);
        return (cfg < 4'd3) ? 4 : int'(cfg) + 1;
    endfunction

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    // Slave model: drives ser_in after each rising ser_clk, captures ser_out on falling ser_clk
    int          sl_left = 0;
    bit          sl_data = 0;
    logic [15:0] sl_reg  = '0;
    logic [15:0] cap     = '0;
    int          ccnt    = 0;

    always @(posedge ser_clk) begin
        logic [15:0] w;
        #1;
        if (sl_left > 0) begin
            ser_in = sl_reg[sl_left-1];
            sl_left--;
            sl_data = 1;
        end else begin
            sl_data = 0;
        end
        if (frm_pulse) begin
            w = (slave_q.size() > 0) ? slave_q.pop_front() : 16'h0;
            w = w & mask_of(cur_len);
            rx_exp.push_back(w);
            sl_reg  = w;
            sl_left = cur_len;
        end
    end

    always @(negedge ser_clk) begin
        logic [15:0] e;
        if (sl_data) begin
            cap = {cap[14:0], ser_out};
            ccnt++;
            if (ccnt == cur_len) begin
                ccnt = 0;
                e = (tx_exp.size() > 0) ? tx_exp.pop_front() : 16'hdead;
                check((cap & mask_of(cur_len)) == e, "R3 R4 R12 serial word", int'(cap & mask_of(cur_len)), int'(e));
            end
        end
    end

    // Monitor: high times of ser_clk / frm_pulse and frame-pulse spacing
    int hi_cnt = 0, fr_cnt = 0, last_rise = -1;
    logic frm_prev = 0;

    always @(negedge clk) begin
        cycle++;
        if (cycle > 150000) begin
            check(0, "watchdog", cycle, 150000);
            finish_run();
        end
        if (!enable || rst) begin
            hi_cnt = 0; fr_cnt = 0; frm_prev = 0;
        end else begin
            if (ser_clk) hi_cnt++;
            else if (hi_cnt > 0) begin
                check(hi_cnt == int'(div_n) + 1, "R5 ser_clk high time", hi_cnt, int'(div_n) + 1);
                hi_cnt = 0;
            end
            if (frm_pulse) fr_cnt++;
            else if (fr_cnt > 0) begin
                check(fr_cnt == 2 * (int'(div_n) + 1), "R2 frame pulse width", fr_cnt, 2 * (int'(div_n) + 1));
                fr_cnt = 0;
            end
            if (frm_pulse && !frm_prev) begin
                if (last_rise >= 0) gaps.push_back(cycle - last_rise);
                last_rise = cycle;
            end
            frm_prev = frm_pulse;
        end
    end

    task automatic push_tx(input logic [15:0] w, input bit expect_taken);
        @(negedge clk);
        tx_push = 1'b1;
        tx_data = w;
        if (expect_taken) tx_exp.push_back(w & mask_of(cur_len));
        @(negedge clk);
        tx_push = 1'b0;
    endtask

    task automatic wait_done();
        while (tx_exp.size() != 0) @(negedge clk);
        repeat (4 * (int'(div_n) + 2)) @(negedge clk);
    endtask

    task automatic pop_check(input string req);
        logic [15:0] e;
        @(negedge clk);
        e = (rx_exp.size() > 0) ? rx_exp.pop_front() : 16'hdead;
        check(rx_data == e, req, int'(rx_data), int'(e));
        rx_pop = 1'b1;
        @(negedge clk);
        rx_pop = 1'b0;
    endtask

    task automatic set_cfg(input logic [3:0] cfg, input logic [7:0] dv);
        @(negedge clk);
        frame_cfg = cfg;
        div_n     = dv;
        cur_len   = len_of(cfg);
    endtask

    task automatic check_gaps(input int n, input string req);
        for (int i = 0; i < n; i++) begin
            int g;
            g = (gaps.size() > 0) ? gaps.pop_front() : -1;
            check(g == cur_len * 2 * (int'(div_n) + 1), req, g, cur_len * 2 * (int'(div_n) + 1));
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(ser_clk == 0 && frm_pulse == 0 && ser_out == 0, "R1 serial lines after reset", {ser_clk, frm_pulse, ser_out}, 0);
        check(rx_empty == 1 && tx_full == 0 && rx_overrun == 0, "R1 flags after reset", {rx_empty, tx_full, rx_overrun}, 3'b100);

        // R1 idle with nothing queued
        set_cfg(4'd7, 8'd1);
        enable = 1'b1;
        repeat (20) @(negedge clk);
        check(ser_clk == 0 && frm_pulse == 0, "R1 idle lines low", {ser_clk, frm_pulse}, 0);

        // Single 8-bit frame, then R7 hold of bit 0 = 1
        slave_q.push_back(16'h00A5);
        push_tx(16'h3C3D, 1);
        wait_done();
        pop_check("R6 single 8-bit receive");
        repeat (20) @(negedge clk);
        check(ser_out == 1'b1, "R7 ser_out holds bit 0", ser_out, 1);
        check(ser_clk == 0 && frm_pulse == 0, "R7 clock and frame low after frame", {ser_clk, frm_pulse}, 0);

        // 16-bit back-to-back frames, div 3 (R9)
        set_cfg(4'd15, 8'd3);
        gaps.delete();
        last_rise = -1;
        slave_q.push_back(16'h8001);
        slave_q.push_back(16'h5AA5);
        push_tx(16'hC3A6, 1);
        push_tx(16'h0FF0, 1);
        wait_done();
        check_gaps(1, "R9 16-bit chained spacing");
        pop_check("R6 16-bit receive first");
        pop_check("R6 16-bit receive second");
        repeat (20) @(negedge clk);
        check(ser_out == 1'b0, "R7 ser_out holds bit 0 of 0x0FF0", ser_out, 0);

        // R4 size values below 3 select 4 bits; div 0
        set_cfg(4'd1, 8'd0);
        slave_q.push_back(16'h0006);
        push_tx(16'hFFFB, 1);
        wait_done();
        pop_check("R4 cfg 1 gives 4-bit receive");
        repeat (10) @(negedge clk);
        check(ser_out == 1'b1, "R7 ser_out holds bit 0 of 4-bit frame", ser_out, 1);

        // 5-bit frame
        set_cfg(4'd4, 8'd2);
        slave_q.push_back(16'h0013);
        push_tx(16'h00EA, 1);
        wait_done();
        pop_check("R4 5-bit receive upper bits zero");

        // R11 push into full tx FIFO ignored, R12 order, R9 chained 8-bit
        set_cfg(4'd7, 8'd1);
        @(negedge clk);
        enable = 1'b0;
        for (int i = 0; i < DEPTH; i++) push_tx(16'(8'h11 * (i + 1)), 1);
        push_tx(16'h00EE, 0);
        @(negedge clk);
        check(tx_full == 1'b1, "R11 tx_full after four pushes", tx_full, 1);
        for (int i = 0; i < DEPTH; i++) slave_q.push_back(16'(8'hC0 + i));
        gaps.delete();
        last_rise = -1;
        @(negedge clk);
        enable = 1'b1;
        wait_done();
        check(gaps.size() == DEPTH - 1, "R11 only four frames sent", gaps.size(), DEPTH - 1);
        check_gaps(DEPTH - 1, "R9 8-bit chained spacing");
        check(rx_overrun == 1'b0, "R10 no overrun with exactly full rx", rx_overrun, 0);

        // R10 overrun: fifth word while rx FIFO full
        slave_q.push_back(16'h007E);
        push_tx(16'h0081, 1);
        wait_done();
        check(rx_overrun == 1'b1, "R10 overrun set", rx_overrun, 1);
        void'(rx_exp.pop_back());
        for (int i = 0; i < DEPTH; i++) pop_check("R10 R12 stored words kept in order");
        check(rx_overrun == 1'b1, "R10 overrun sticky", rx_overrun, 1);

        // R11 empty rx reads zero, pop has no effect
        @(negedge clk);
        check(rx_empty == 1'b1 && rx_data == 16'h0, "R11 empty reads zero", int'(rx_data), 0);
        rx_pop = 1'b1;
        @(negedge clk);
        rx_pop = 1'b0;
        @(negedge clk);
        check(rx_empty == 1'b1 && rx_data == 16'h0, "R11 pop on empty no effect", {rx_empty, rx_data}, 17'h10000);

        // R8 disable mid-frame
        set_cfg(4'd15, 8'd2);
        slave_q.push_back(16'hFFFF);
        push_tx(16'hFFFF, 1);
        while (!frm_pulse) @(negedge clk);
        repeat (30) @(negedge clk);
        enable = 1'b0;
        repeat (2) @(negedge clk);
        check(ser_out == 0 && ser_clk == 0 && frm_pulse == 0, "R8 lines forced low when disabled", {ser_clk, frm_pulse, ser_out}, 0);
        tx_exp.delete();
        rx_exp.delete();
        sl_left = 0; sl_data = 0; ccnt = 0;
        repeat (20) @(negedge clk);
        check(ser_out == 0 && ser_clk == 0 && rx_empty == 1, "R8 abandoned frame stays quiet", {ser_clk, ser_out, rx_empty}, 1);

        finish_run();
    end
endmodule